// File: doc/BRIEF.md
# Translated Block Address Lookup

This block is a small fully associative table holding the start addresses of code blocks that have already been turned into fabric configurations. Each cycle that the host presents a fetch address, the block compares it against every valid entry. If one matches, the block reports the hit and the matching slot number in the same cycle. The slot number is used directly as the address into configuration storage. On a hit the block also raises a one-cycle start strobe for the fabric and stalls the host until the fabric reports completion.

The translation logic adds entries through an insert port. An insert of an address that is already stored reuses its slot. An insert of a new address takes the lowest-numbered empty slot. When no slot is empty, it overwrites a slot chosen in round-robin order. A flush input empties the whole table in one cycle.

Top module: `xlat_lookup`

## Requirements
- R1: After reset the table is empty: `hitOut`, `fabricStart` and `stallOut` are low for any fetch address.
- R2: While not stalled, `hitOut` is high in the same cycle that `fetchValid` is high and `fetchPc` equals a valid entry, and `hitIdx` then gives that entry's slot number (0 to ENTRIES-1).
- R3: An insert of an address not in the table writes the lowest-numbered empty slot. The entry is visible to lookups from the cycle after the insert.
- R4: An insert of an address already in the table rewrites that same slot. It uses no other slot and does not advance the replacement pointer, so each address is held by at most one slot.
- R5: When every slot is valid, an insert of a new address overwrites the slot given by a round-robin pointer. The pointer starts at 0 after reset and advances by one, wrapping, on each such overwrite. The overwritten address then misses.
- R6: A hit raises `fabricStart` for exactly that cycle and raises `stallOut` in that cycle. `stallOut` stays high until the cycle in which `fabricDone` is high, and is low from the next cycle.
- R7: While stalled after a hit, a fetch that matches a valid entry produces neither `hitOut` nor `fabricStart`.
- R8: `flush` clears every entry in one cycle, so all lookups miss from the next cycle. When `flush` and an insert fall in the same cycle, the flush wins and the inserted address is not stored.
- R9: When a lookup and an insert of the same new address fall in the same cycle, the lookup misses in that cycle and the address hits from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetchValid | input | 1 | Fetch address is present this cycle |
| fetchPc | input | ADDR_W | Fetch address to look up |
| insValid | input | 1 | Insert request from the translation logic |
| insAddr | input | ADDR_W | Block start address to insert |
| flush | input | 1 | Clear all entries |
| fabricDone | input | 1 | Fabric has finished the running configuration |
| hitOut | output | 1 | Lookup hit this cycle |
| hitIdx | output | IDX_W | Slot number of the hit (configuration index) |
| fabricStart | output | 1 | One-cycle start strobe to the fabric |
| stallOut | output | 1 | Stall request to the host pipeline |

## Verification
The table can be read by a lookup and written by an insert in the same cycle. The bench provokes this by presenting a fetch address and an insert of that same new address on one clock. It expects a miss in that cycle, because the lookup sees the contents from before the write, and a hit with the newly written slot one cycle later. Flush against insert is handled the same way: both are driven together, and the bench confirms with a lookup on the next cycle that the flush took priority.

// File: rtl/xlat_lookup_pkg.sv
package xlat_lookup_pkg;
  // Write strobes sent from the control module to the datapath
  typedef struct packed {
    logic wrEn;     // write an entry this cycle
    logic selMatch; // write into the slot already holding insAddr
    logic selFree;  // write into the lowest empty slot
    logic clrAll;   // drop every valid bit
  } tblCmd_t;
endpackage

// File: rtl/xlat_lookup_dp.sv
module xlat_lookup_dp
  import xlat_lookup_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tblCmd_t           cmd,
  input  logic [IDX_W-1:0]  victimIdx,
  input  logic [ADDR_W-1:0] fetchPc,
  input  logic [ADDR_W-1:0] insAddr,
  output logic              fetchMatch,
  output logic [IDX_W-1:0]  fetchIdx,
  output logic              insMatch,
  output logic              freeAny
);
  logic [ADDR_W-1:0] addrQ [ENTRIES];
  logic [ENTRIES-1:0] validQ;
  logic [ENTRIES-1:0] fetchVec, insVec;
  logic [IDX_W-1:0] insIdx, freeIdx, wrIdx;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_cmp
      assign fetchVec[g] = validQ[g] && (addrQ[g] == fetchPc);
      assign insVec[g]   = validQ[g] && (addrQ[g] == insAddr);
    end
  endgenerate

  always_comb begin
    fetchIdx = '0;
    insIdx   = '0;
    freeIdx  = '0;
    freeAny  = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (fetchVec[i]) fetchIdx = IDX_W'(i);
      if (insVec[i])   insIdx   = IDX_W'(i);
    end
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!validQ[i]) begin
        freeIdx = IDX_W'(i);
        freeAny = 1'b1;
      end
    end
  end

  assign fetchMatch = |fetchVec;
  assign insMatch   = |insVec;
  assign wrIdx = cmd.selMatch ? insIdx : (cmd.selFree ? freeIdx : victimIdx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      validQ <= '0;
    end else if (cmd.clrAll) begin
      validQ <= '0;
    end else if (cmd.wrEn) begin
      validQ[wrIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (cmd.wrEn && !cmd.clrAll) addrQ[wrIdx] <= insAddr;
  end

  // R4: an address is never held twice
  a_r4_unique_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fetchVec));
  // R8: a clear leaves the table empty on the next cycle
  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.clrAll |=> (validQ == '0));
endmodule

// File: rtl/xlat_lookup_ctl.sv
module xlat_lookup_ctl
  import xlat_lookup_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetchValid,
  input  logic             fetchMatch,
  input  logic             insValid,
  input  logic             insMatch,
  input  logic             freeAny,
  input  logic             flush,
  input  logic             fabricDone,
  output tblCmd_t          cmd,
  output logic [IDX_W-1:0] victimIdx,
  output logic             hitOut,
  output logic             fabricStart,
  output logic             stallOut
);
  logic busyQ;
  logic [IDX_W-1:0] rrQ;
  logic useVictim;

  always_comb begin
    cmd.clrAll   = flush;
    cmd.wrEn     = insValid && !flush;
    cmd.selMatch = insMatch;
    cmd.selFree  = !insMatch && freeAny;
  end

  assign useVictim   = cmd.wrEn && !insMatch && !freeAny;
  assign victimIdx   = rrQ;
  assign hitOut      = fetchValid && fetchMatch && !busyQ;
  assign fabricStart = hitOut;
  assign stallOut    = hitOut || busyQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busyQ <= 1'b0;
      rrQ   <= '0;
    end else begin
      if (hitOut)                busyQ <= 1'b1;
      else if (busyQ && fabricDone) busyQ <= 1'b0;
      if (useVictim) rrQ <= (rrQ == IDX_W'(ENTRIES - 1)) ? '0 : rrQ + 1'b1;
    end
  end

  // R6: stall holds while the fabric has not finished
  a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (stallOut && !fabricDone) |=> stallOut);
  // R6: the start strobe never lasts two cycles
  a_r6_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fabricStart |=> !fabricStart);
  // R7: no new start while the fabric runs
  a_r7_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busyQ |-> !fabricStart);
  // R5: the victim pointer moves only on a replacement
  a_r5_rr_steady: assert property (@(posedge clk) disable iff (!rst_n)
    !useVictim |=> $stable(rrQ));
endmodule

// File: rtl/xlat_lookup.sv
module xlat_lookup
  import xlat_lookup_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetchValid,
  input  logic [ADDR_W-1:0] fetchPc,
  input  logic              insValid,
  input  logic [ADDR_W-1:0] insAddr,
  input  logic              flush,
  input  logic              fabricDone,
  output logic              hitOut,
  output logic [IDX_W-1:0]  hitIdx,
  output logic              fabricStart,
  output logic              stallOut
);
  tblCmd_t cmd;
  logic [IDX_W-1:0] victimIdx;
  logic fetchMatch, insMatch, freeAny;

  xlat_lookup_dp #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) i_dp (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .victimIdx(victimIdx),
    .fetchPc(fetchPc), .insAddr(insAddr), .fetchMatch(fetchMatch),
    .fetchIdx(hitIdx), .insMatch(insMatch), .freeAny(freeAny)
  );

  xlat_lookup_ctl #(.ENTRIES(ENTRIES)) i_ctl (
    .clk(clk), .rst_n(rst_n), .fetchValid(fetchValid), .fetchMatch(fetchMatch),
    .insValid(insValid), .insMatch(insMatch), .freeAny(freeAny), .flush(flush),
    .fabricDone(fabricDone), .cmd(cmd), .victimIdx(victimIdx), .hitOut(hitOut),
    .fabricStart(fabricStart), .stallOut(stallOut)
  );
endmodule

// File: tb/test_xlat_lookup.sv
module test_xlat_lookup;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fetchValid = 1'b0, insValid = 1'b0, flush = 1'b0, fabricDone = 1'b0;
  logic [31:0] fetchPc = '0, insAddr = '0;
  logic hitOut, fabricStart, stallOut;
  logic [3:0] hitIdx;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  // {pc, expected hit, expected slot} after slot i holds 0x1000 + i*0x40
  localparam logic [36:0] VEC [8] = '{
    {32'h0000_1000, 1'b1, 4'd0},
    {32'h0000_1040, 1'b1, 4'd1},
    {32'h0000_13C0, 1'b1, 4'd15},
    {32'h0000_1200, 1'b1, 4'd8},
    {32'h0000_1004, 1'b0, 4'd0},
    {32'h0000_0000, 1'b0, 4'd0},
    {32'h0000_1400, 1'b0, 4'd0},
    {32'h0000_12C0, 1'b1, 4'd11}
  };

  xlat_lookup i_xlat_lookup (
    .clk(clk), .rst_n(rst_n), .fetchValid(fetchValid), .fetchPc(fetchPc),
    .insValid(insValid), .insAddr(insAddr), .flush(flush), .fabricDone(fabricDone),
    .hitOut(hitOut), .hitIdx(hitIdx), .fabricStart(fabricStart), .stallOut(stallOut)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic insert(input logic [31:0] a);
    @(negedge clk);
    insValid = 1'b1; insAddr = a;
    @(negedge clk);
    insValid = 1'b0;
  endtask

  // look up without letting the hit reach a clock edge
  task automatic probe(input logic [31:0] pc, input string req,
                       input logic expHit, input logic [3:0] expIdx);
    @(negedge clk);
    fetchValid = 1'b1; fetchPc = pc;
    #1;
    check(req, {31'd0, hitOut}, {31'd0, expHit});
    if (expHit) check(req, {28'd0, hitIdx}, {28'd0, expIdx});
    fetchValid = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    fetchValid = 1'b1; fetchPc = 32'h0; #1;
    check("R1 hit", {31'd0, hitOut}, 32'd0);
    check("R1 stall", {31'd0, stallOut}, 32'd0);
    check("R1 start", {31'd0, fabricStart}, 32'd0);
    fetchValid = 1'b0;

    // R3 fill in slot order
    for (int i = 0; i < N; i++) insert(32'h1000 + 32'(i) * 32'h40);
    // R2 vector walk
    for (int v = 0; v < 8; v++) probe(VEC[v][36:5], "R2", VEC[v][4], VEC[v][3:0]);

    // R4 duplicate while full must not advance the victim pointer
    insert(32'h1140);
    probe(32'h1140, "R4 dup kept", 1'b1, 4'd5);
    // R5 round robin 0 then 1
    insert(32'h8000);
    probe(32'h8000, "R5 first victim", 1'b1, 4'd0);
    probe(32'h1000, "R5 evicted", 1'b0, 4'd0);
    insert(32'h8040);
    probe(32'h8040, "R5 second victim", 1'b1, 4'd1);
    probe(32'h1140, "R4 slot5 intact", 1'b1, 4'd5);

    // R8 flush empties all
    do_flush();
    probe(32'h8000, "R8 flushed", 1'b0, 4'd0);
    probe(32'h13C0, "R8 flushed", 1'b0, 4'd0);

    // R3 lowest empty slot after flush, R4 duplicate uses no slot
    insert(32'hA000);
    insert(32'hA000);
    insert(32'hB000);
    probe(32'hB000, "R4 no extra slot", 1'b1, 4'd1);

    // R8 flush beats insert
    @(negedge clk);
    flush = 1'b1; insValid = 1'b1; insAddr = 32'hC000;
    @(negedge clk);
    flush = 1'b0; insValid = 1'b0;
    probe(32'hC000, "R8 flush wins", 1'b0, 4'd0);
    probe(32'hA000, "R8 flush wins", 1'b0, 4'd0);

    // R9 same-cycle lookup and insert
    @(negedge clk);
    insValid = 1'b1; insAddr = 32'hD000; fetchValid = 1'b1; fetchPc = 32'hD000;
    #1;
    check("R9 miss same cycle", {31'd0, hitOut}, 32'd0);
    @(negedge clk);
    insValid = 1'b0; #1;
    check("R9 hit next cycle", {31'd0, hitOut}, 32'd1);
    check("R9 idx", {28'd0, hitIdx}, 32'd0);
    fetchValid = 1'b0;

    // R6 / R7 stall sequence
    @(negedge clk);
    fetchValid = 1'b1; fetchPc = 32'hD000; #1;
    check("R6 start", {31'd0, fabricStart}, 32'd1);
    check("R6 stall", {31'd0, stallOut}, 32'd1);
    @(negedge clk); #1;
    check("R7 no hit", {31'd0, hitOut}, 32'd0);
    check("R7 no start", {31'd0, fabricStart}, 32'd0);
    check("R6 held", {31'd0, stallOut}, 32'd1);
    fetchValid = 1'b0;
    repeat (3) @(negedge clk);
    #1 check("R6 held long", {31'd0, stallOut}, 32'd1);
    @(negedge clk); fabricDone = 1'b1; #1;
    check("R6 done cycle", {31'd0, stallOut}, 32'd1);
    @(negedge clk); fabricDone = 1'b0; #1;
    check("R6 released", {31'd0, stallOut}, 32'd0);
    probe(32'hD000, "R6 lookup again", 1'b1, 4'd0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule